// File: doc/BRIEF.md
# Dual-Halfword Saturating Add/Subtract Unit

This block performs packed arithmetic on two 32-bit operands. Each operand is read as two signed 16-bit lanes. For each lane the block forms a sum or a difference at full precision and then clamps it to the signed 16-bit range. It offers four pairings of the lanes. Two of them keep the lanes straight, one adding and one subtracting. The other two cross the second operand's lanes, so that the low lane of one operand meets the high lane of the other.

The block also decodes the 32-bit instruction word. Two register indices leave it at once, so a register file outside the block can supply the operands in the same cycle. The destination index, the result, per-lane saturation flags and a write enable are registered and appear one cycle after a valid input. The write enable depends on the condition field of the instruction and on a condition-pass signal that is evaluated outside the block. Selector codes that the block does not support raise an invalid flag and never write.

Top module: `dhs_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid, out_write, out_invalid and out_sat are all 0.
- R2: Selector 0 adds matching lanes: low = A[15:0] + B[15:0], high = A[31:16] + B[31:16], each then saturated.
- R3: Selector 3 subtracts matching lanes, A minus B, in both lanes, each then saturated.
- R4: Selector 1 crosses the lanes: low = A.low − B.high, high = A.high + B.low, each then saturated.
- R5: Selector 2 crosses the lanes: low = A.low + B.high, high = A.high − B.low, each then saturated.
- R6: Each lane saturates on its own. A value above 32767 becomes 0x7FFF and a value below −32768 becomes 0x8000. out_sat[0] flags the low lane and out_sat[1] flags the high lane. A lane that does not overflow is unaffected by the other lane.
- R7: out_valid follows in_valid one cycle later. The low lane result sits in out_result[15:0] and the high lane result in out_result[31:16].
- R8: The instruction fields are read as follows. src_a_idx = instr[19:16] and src_b_idx = instr[3:0], both combinational. op_group = instr[21:20], also combinational. out_dest = instr[15:12], registered. The condition is instr[31:28] and the selector is instr[7:5].
- R9: A condition value of 0xE always writes. Any other condition value sets out_write only when cond_ok is 1 in the input cycle.
- R10: Selector values 4 to 7 set out_invalid. In that case out_write and out_sat are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First operand (A) |
| opb | input | 32 | Second operand (B) |
| cond_ok | input | 1 | Condition evaluated true outside the block |
| src_a_idx | output | 4 | Register index of operand A |
| src_b_idx | output | 4 | Register index of operand B |
| op_group | output | 2 | Opcode group field |
| out_valid | output | 1 | Registered result present |
| out_write | output | 1 | Result should be written back |
| out_invalid | output | 1 | Unsupported selector seen |
| out_dest | output | 4 | Destination register index |
| out_result | output | 32 | Packed saturated result |
| out_sat | output | 2 | Per-lane saturation flags (bit 0 low lane, bit 1 high lane) |

## Verification
Each selector is applied to operands with distinct values in every lane. A swapped lane or a sign flipped in a single lane would therefore change the result, which separates the straight pairings from the crossed ones. Lane values near both limits then push one lane or both lanes past the range, in the same direction or in opposite directions. These cases show whether the clamp and its flag stay with their own lane. Runs of mixed random operands and conditions cover sums just inside and just outside the range. Condition codes other than 0xE, with cond_ok low and high, and selectors 4 to 7 separate the write gating from the arithmetic.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
    parameter int INSTR_W = 32;

    localparam logic [3:0] COND_ALWAYS = 4'hE;
    localparam logic [2:0] SEL_ADD = 3'd0;
    localparam logic [2:0] SEL_ASX = 3'd1;
    localparam logic [2:0] SEL_SAX = 3'd2;
    localparam logic [2:0] SEL_SUB = 3'd3;

    typedef struct packed {
        logic [3:0] cond;
        logic [1:0] grp;
        logic [3:0] rn;
        logic [3:0] rd;
        logic [3:0] rm;
        logic [2:0] sel;
    } dec_t;

    typedef struct packed {
        logic swap;
        logic sub;
    } lane_ctl_t;

    function automatic lane_ctl_t ctl_for(input logic [2:0] sel, input logic hi);
        lane_ctl_t c;
        c.swap = (sel == SEL_ASX) || (sel == SEL_SAX);
        if (hi) c.sub = (sel == SEL_SAX) || (sel == SEL_SUB);
        else    c.sub = (sel == SEL_ASX) || (sel == SEL_SUB);
        return c;
    endfunction

    function automatic logic sel_supported(input logic [2:0] sel);
        return sel[2] == 1'b0;
    endfunction
endpackage

// File: rtl/dhs_decode.sv
module dhs_decode
    import dhs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec.cond = instr[31:28];
        dec.grp  = instr[21:20];
        dec.rn   = instr[19:16];
        dec.rd   = instr[15:12];
        dec.rm   = instr[3:0];
        dec.sel  = instr[7:5];
    end
endmodule

// File: rtl/dhs_lane.sv
module dhs_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         sat
);
    logic [W:0] ext_a, ext_b, full;

    always_comb begin
        ext_a = {a[W-1], a};
        ext_b = {b[W-1], b};
        full  = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        sat   = full[W] ^ full[W-1];
        res   = sat ? {full[W], {(W-1){~full[W]}}} : full[W-1:0];
    end
endmodule

// File: rtl/dhs_unit.sv
module dhs_unit
    import dhs_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [2*LANE_W-1:0] opa,
    input  logic [2*LANE_W-1:0] opb,
    input  logic                cond_ok,
    output logic [3:0]          src_a_idx,
    output logic [3:0]          src_b_idx,
    output logic [1:0]          op_group,
    output logic                out_valid,
    output logic                out_write,
    output logic                out_invalid,
    output logic [3:0]          out_dest,
    output logic [2*LANE_W-1:0] out_result,
    output logic [1:0]          out_sat
);
    localparam int NLANE  = 2;
    localparam int WORD_W = NLANE * LANE_W;

    dec_t dec;
    dhs_decode u_dec (.instr(instr), .dec(dec));

    assign src_a_idx = dec.rn;
    assign src_b_idx = dec.rm;
    assign op_group  = dec.grp;

    logic [WORD_W-1:0] lane_res;
    logic [NLANE-1:0]  lane_sat;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        lane_ctl_t         ctl;
        logic [LANE_W-1:0] b_pick;
        assign ctl    = ctl_for(dec.sel, i == 1);
        assign b_pick = ctl.swap ? opb[(NLANE-1-i)*LANE_W +: LANE_W]
                                 : opb[i*LANE_W +: LANE_W];
        dhs_lane #(.W(LANE_W)) u_lane (
            .a   (opa[i*LANE_W +: LANE_W]),
            .b   (b_pick),
            .sub (ctl.sub),
            .res (lane_res[i*LANE_W +: LANE_W]),
            .sat (lane_sat[i])
        );
    end

    logic supported, cond_pass;
    assign supported = sel_supported(dec.sel);
    assign cond_pass = (dec.cond == COND_ALWAYS) || cond_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_write   <= 1'b0;
            out_invalid <= 1'b0;
            out_sat     <= '0;
            out_dest    <= '0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_write   <= in_valid && supported && cond_pass;
            out_invalid <= in_valid && !supported;
            out_sat     <= (in_valid && supported) ? lane_sat : '0;
            if (in_valid) begin
                out_dest   <= dec.rd;
                out_result <= supported ? lane_res : '0;
            end
        end
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (!out_write && out_sat == 2'b00));
    p_always_cond_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:28] == 4'hE && instr[7] == 1'b0) |=> out_write);
    p_gated_cond_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:28] != 4'hE && !cond_ok) |=> !out_write);
    p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
        out_sat[0] |-> (out_result[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}} ||
                        out_result[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}}));
    p_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
        out_sat[1] |-> (out_result[WORD_W-1:LANE_W] == {1'b0, {(LANE_W-1){1'b1}}} ||
                        out_result[WORD_W-1:LANE_W] == {1'b1, {(LANE_W-1){1'b0}}}));
    p_write_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (out_write || out_invalid) |-> out_valid);
endmodule

// File: tb/sim_dhs_unit.sv
module sim_dhs_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, opa, opb;
    logic        cond_ok;
    logic [3:0]  src_a_idx, src_b_idx, out_dest;
    logic [1:0]  op_group, out_sat;
    logic        out_valid, out_write, out_invalid;
    logic [31:0] out_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dhs_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .opa(opa),
        .opb(opb), .cond_ok(cond_ok), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .op_group(op_group), .out_valid(out_valid), .out_write(out_write),
        .out_invalid(out_invalid), .out_dest(out_dest), .out_result(out_result),
        .out_sat(out_sat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] rn,
                                       input logic [3:0] rd, input logic [3:0] rm,
                                       input logic [1:0] g, input logic [2:0] s);
        return {c, 6'b000110, g, rn, rd, 4'b1111, s, 1'b1, rm};
    endfunction

    function automatic int clamp(input int v, output bit s);
        s = (v > 32767) || (v < -32768);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic ok);
        int al, ah, bl, bh, lo, hi;
        bit sl, sh, sup, wr;
        logic [15:0] l16, h16;
        @(negedge clk);
        in_valid = 1'b1; instr = ins; opa = a; opb = b; cond_ok = ok;
        #1;
        check({tag, " R8 src_a"}, {28'd0, src_a_idx}, {28'd0, ins[19:16]});
        check({tag, " R8 src_b"}, {28'd0, src_b_idx}, {28'd0, ins[3:0]});
        check({tag, " R8 group"}, {30'd0, op_group}, {30'd0, ins[21:20]});
        al = $signed(a[15:0]); ah = $signed(a[31:16]);
        bl = $signed(b[15:0]); bh = $signed(b[31:16]);
        case (ins[7:5])
            3'd0: begin lo = al + bl; hi = ah + bh; end
            3'd1: begin lo = al - bh; hi = ah + bl; end
            3'd2: begin lo = al + bh; hi = ah - bl; end
            3'd3: begin lo = al - bl; hi = ah - bh; end
            default: begin lo = 0; hi = 0; end
        endcase
        lo = clamp(lo, sl); hi = clamp(hi, sh);
        sup = (ins[7:5] < 3'd4);
        wr  = sup && (ins[31:28] == 4'hE || ok);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R7 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " R9 write"}, {31'd0, out_write}, {31'd0, wr});
        check({tag, " R10 invalid"}, {31'd0, out_invalid}, {31'd0, !sup});
        check({tag, " R8 dest"}, {28'd0, out_dest}, {28'd0, ins[15:12]});
        if (sup) begin
            l16 = 16'(lo); h16 = 16'(hi);
            check({tag, " R2-5 result"}, out_result, {h16, l16});
            check({tag, " R6 sat"}, {30'd0, out_sat}, {30'd0, sh, sl});
        end else begin
            check({tag, " R10 sat"}, {30'd0, out_sat}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opa = '0; opb = '0; cond_ok = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 write", {31'd0, out_write}, 32'd0);
        check("R1 invalid", {31'd0, out_invalid}, 32'd0);
        check("R1 sat", {30'd0, out_sat}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post valid", {31'd0, out_valid}, 32'd0);
        check("R7 idle", {31'd0, out_valid}, 32'd0);

        run("R2 add",  mk(4'hE, 4'd1, 4'd2, 4'd3, 2'b10, 3'd0), 32'h0003_0100, 32'h0020_0005, 1'b0);
        run("R3 sub",  mk(4'hE, 4'd4, 4'd5, 4'd6, 2'b10, 3'd3), 32'h0003_0100, 32'h0020_0005, 1'b0);
        run("R4 asx",  mk(4'hE, 4'd7, 4'd8, 4'd9, 2'b10, 3'd1), 32'h1000_0100, 32'h0020_0005, 1'b0);
        run("R5 sax",  mk(4'hE, 4'hA, 4'hB, 4'hC, 2'b10, 3'd2), 32'h1000_0100, 32'h0020_0005, 1'b0);
        run("R6 posboth", mk(4'hE, 4'd1, 4'd1, 4'd1, 2'b10, 3'd0), 32'h7FF0_7FFF, 32'h0100_0001, 1'b0);
        run("R6 negboth", mk(4'hE, 4'd1, 4'd1, 4'd1, 2'b10, 3'd3), 32'h8000_8005, 32'h0001_0010, 1'b0);
        run("R6 opposite", mk(4'hE, 4'd1, 4'd1, 4'd1, 2'b10, 3'd1), 32'h7FFF_8000, 32'h0001_0001, 1'b0);
        run("R6 onelane", mk(4'hE, 4'd1, 4'd1, 4'd1, 2'b10, 3'd2), 32'h1234_7FFF, 32'h0002_0001, 1'b0);
        run("R6 edge", mk(4'hE, 4'd1, 4'd1, 4'd1, 2'b10, 3'd0), 32'h8000_7FFE, 32'h0000_0001, 1'b0);
        run("R9 gated off", mk(4'h0, 4'd2, 4'd3, 4'd4, 2'b10, 3'd0), 32'h1, 32'h2, 1'b0);
        run("R9 gated on",  mk(4'h0, 4'd2, 4'd3, 4'd4, 2'b10, 3'd0), 32'h1, 32'h2, 1'b1);
        run("R9 F off",     mk(4'hF, 4'd2, 4'd3, 4'd4, 2'b10, 3'd3), 32'h1, 32'h2, 1'b0);
        for (int s = 4; s < 8; s++)
            run("R10 unsup", mk(4'hE, 4'd5, 4'd6, 4'd7, 2'b10, 3'(s)), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b1);
        for (int k = 0; k < 300; k++)
            run("rand", mk(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                           2'($urandom), 3'($urandom_range(0, 4))),
                $urandom, $urandom, 1'($urandom));
        @(negedge clk);
        check("R7 after idle", {31'd0, out_valid}, 32'd0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule